// File: doc/BRIEF.md
# Indirect Channel Pointer Register Window

This block holds one descriptor pointer per hardware channel of a DMA-style transfer engine and exposes all of them to the CPU through a single 32-bit register window. The low byte of the window is a channel selector. The pointer field in bits [29:16] always shows, and on a write updates, the entry that the selector names. Software selects a channel with a write to byte lane 0, then reads or writes the pointer with a halfword access to the upper half. A full word write sets the selector and the pointer together, and the pointer lands in the entry named by the new selector value.

On the engine side, a lookup port returns the pointer for a requested channel one cycle after the request. A one-entry buffer remembers the last channel looked up and its pointer. Later requests for that channel are served from the buffer, even if software has since rewritten the entry. Any change of the configuration bit `cfg_rbdis`, in either direction, discards the buffer, so the next request reads the bank again.

Top module: `chptr_window`

## Requirements
- R1: Reset clears the selector, every pointer entry and the buffer valid flag. The first request after reset reads the bank.
- R2: A write with `cpu_be[0]` set, while `eng_normal` is high, loads `cpu_wdata[7:0]` into the selector. `cpu_rdata[7:0]` shows the selector.
- R3: A write with both `cpu_be[2]` and `cpu_be[3]` set stores `cpu_wdata[29:16]` into the entry named by the selector. `cpu_rdata[29:16]` shows that entry, and `cpu_rdata` bits [15:8] and [31:30] read as zero.
- R4: A write with all four lanes enabled updates the selector and stores the pointer into the entry named by the new selector value, in the same cycle.
- R5: While `eng_normal` is low, writes change nothing and `cpu_rdata` reads zero.
- R6: A selector value of NUM_CH or above names no entry. The pointer field then reads zero, and pointer writes change no entry.
- R7: A write that enables only one of lanes 2 and 3 leaves every pointer entry unchanged.
- R8: Each cycle with `req_valid` high gives exactly one cycle of `rsp_valid` in the next cycle, with `rsp_ptr` carrying the pointer for `req_chan`.
- R9: A request for the channel held in a valid buffer returns the buffered pointer, even after software has rewritten that entry.
- R10: A request for a channel other than the buffered one reads the bank and replaces the buffer contents with that channel and pointer.
- R11: A change of `cfg_rbdis` in either direction invalidates the buffer. The next request reads the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eng_normal | input | 1 | Engine is in its normal state; gates all CPU access |
| cpu_wr | input | 1 | CPU write strobe for the window |
| cpu_be | input | 4 | Byte lane enables of the write |
| cpu_wdata | input | 32 | Write data, window layout |
| cpu_rdata | output | 32 | Window read view: selector [7:0], pointer [29:16] |
| cfg_rbdis | input | 1 | Configuration bit; any change flushes the buffer |
| req_valid | input | 1 | Engine pointer lookup request |
| req_chan | input | $clog2(NUM_CH) | Channel of the lookup |
| rsp_valid | output | 1 | Lookup result strobe, one cycle after the request |
| rsp_ptr | output | 14 | Looked-up pointer |

## Verification
A corrupted selector shows up on the first read. The low byte of `cpu_rdata` changes right away, and the pointer field then reflects the wrong entry. A wrong buffer valid or channel flag stays hidden until the next lookup. It then appears as a stale or fresh pointer on `rsp_ptr`, one cycle after the request, where the opposite was expected. The bench therefore rewrites entries between repeated requests and toggles `cfg_rbdis` both ways, so that buffered and bank values differ whenever they are compared. A misrouted bank write is caught by sweeping the selector across all entries and reading each one back.

// File: rtl/chptr_pkg.sv
// Package: shared constants and the bank write command used across the
// channel pointer window. Assumes a 32-bit CPU window with byte lanes.
package chptr_pkg;

    localparam int PTR_W   = 14;   // width of one descriptor pointer
    localparam int SEL_W   = 8;    // width of the channel selector field
    localparam int PTR_LSB = 16;   // bit position of the pointer field
    localparam int WIN_W   = 32;   // window width

    // One write into the pointer bank.
    typedef struct packed {
        logic             we;
        logic [SEL_W-1:0] idx;
        logic [PTR_W-1:0] val;
    } bank_wr_t;

    // Build the window read view from selector and selected pointer.
    function automatic logic [WIN_W-1:0] pack_window(
        input logic [SEL_W-1:0] sel,
        input logic [PTR_W-1:0] ptr
    );
        logic [WIN_W-1:0] w;
        w = '0;
        w[SEL_W-1:0]               = sel;
        w[PTR_LSB +: PTR_W]        = ptr;
        return w;
    endfunction

endpackage

// File: rtl/chptr_decode.sv
// Module: CPU-side decode of the register window. Holds the channel
// selector and turns lane-enabled writes into bank write commands.
// Assumes writes are single-cycle strobes and that eng_normal gates all
// access; the pointer target is the selector value after this write.
module chptr_decode
    import chptr_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eng_normal,
    input  logic             cpu_wr,
    input  logic [3:0]       cpu_be,
    input  logic [WIN_W-1:0] cpu_wdata,
    output logic [SEL_W-1:0] sel_q,
    output bank_wr_t         bank_wr
);

    logic             sel_we;
    logic             ptr_we_raw;
    logic [SEL_W-1:0] sel_next;
    logic             sel_in_range;

    // Decode which fields this write touches.
    always_comb begin
        sel_we       = eng_normal && cpu_wr && cpu_be[0];
        ptr_we_raw   = eng_normal && cpu_wr && cpu_be[2] && cpu_be[3];
        sel_next     = sel_we ? cpu_wdata[SEL_W-1:0] : sel_q;
        sel_in_range = (32'(sel_next) < NUM_CH);
    end

    // Form the bank write command aimed at the post-write selector.
    always_comb begin
        bank_wr.we  = ptr_we_raw && sel_in_range;
        bank_wr.idx = sel_next;
        bank_wr.val = cpu_wdata[PTR_LSB +: PTR_W];
    end

    // Selector register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (sel_we) begin
            sel_q <= cpu_wdata[SEL_W-1:0];
        end
    end

    AST_SEL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_normal |=> $stable(sel_q)); // R5

    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_normal && cpu_wr && cpu_be[0]) |=> sel_q == $past(cpu_wdata[SEL_W-1:0])); // R2

    AST_PTR_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr.we |-> (cpu_be[2] && cpu_be[3])); // R7

endmodule

// File: rtl/chptr_bank.sv
// Module: the per-channel pointer bank with one write port and two
// combinational read ports (CPU selector and engine lookup).
// Assumes the write index is already range-checked by the decoder;
// out-of-range read indices return zero.
module chptr_bank
    import chptr_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int IDX_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bank_wr_t         bank_wr,
    input  logic [SEL_W-1:0] cpu_idx,
    output logic [PTR_W-1:0] cpu_ptr,
    input  logic [IDX_W-1:0] eng_idx,
    output logic [PTR_W-1:0] eng_ptr
);

    logic [PTR_W-1:0] ent [NUM_CH];

    // Entry storage: clear on reset, write the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) ent[i] <= '0;
        end else if (bank_wr.we) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (bank_wr.idx == SEL_W'(i)) ent[i] <= bank_wr.val;
            end
        end
    end

    // CPU read port: entry named by the selector, zero when none.
    always_comb begin
        cpu_ptr = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (cpu_idx == SEL_W'(i)) cpu_ptr = ent[i];
        end
    end

    // Engine read port: entry named by the lookup channel.
    always_comb begin
        eng_ptr = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (eng_idx == IDX_W'(i)) eng_ptr = ent[i];
        end
    end

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr.we |-> (32'(bank_wr.idx) < NUM_CH)); // R6

    // Per-entry guards: an entry moves only when it is addressed.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ent_chk
        AST_ENTRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(bank_wr.we && bank_wr.idx == SEL_W'(g)) |=> $stable(ent[g])); // R3
        AST_ENTRY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (bank_wr.we && bank_wr.idx == SEL_W'(g)) |=> ent[g] == $past(bank_wr.val)); // R4
    end

endmodule

// File: rtl/chptr_rbuf.sv
// Module: engine lookup with a one-entry pointer buffer. A hit returns
// the buffered pointer; a miss reads the bank and refills the buffer.
// Any change of the configuration bit flushes the buffer, and a flush
// seen in the same cycle as a request forces that request to miss.
module chptr_rbuf
    import chptr_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_rbdis,
    input  logic             req_valid,
    input  logic [IDX_W-1:0] req_chan,
    input  logic [PTR_W-1:0] bank_ptr,
    output logic             rsp_valid,
    output logic [PTR_W-1:0] rsp_ptr
);

    logic             rbdis_q;
    logic             flush;
    logic             buf_valid;
    logic [IDX_W-1:0] buf_chan;
    logic [PTR_W-1:0] buf_ptr;
    logic             hit;

    // Detect a change of the configuration bit and decide hit or miss.
    always_comb begin
        flush = (cfg_rbdis != rbdis_q);
        hit   = buf_valid && !flush && (buf_chan == req_chan);
    end

    // Remember the last seen configuration bit.
    always_ff @(posedge clk) begin
        if (!rst_n) rbdis_q <= 1'b0;
        else        rbdis_q <= cfg_rbdis;
    end

    // Buffer: refill on miss, drop on flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_valid <= 1'b0;
            buf_chan  <= '0;
            buf_ptr   <= '0;
        end else if (req_valid && !hit) begin
            buf_valid <= 1'b1;
            buf_chan  <= req_chan;
            buf_ptr   <= bank_ptr;
        end else if (flush) begin
            buf_valid <= 1'b0;
        end
    end

    // Response register: one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_ptr   <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) rsp_ptr <= hit ? buf_ptr : bank_ptr;
        end
    end

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R8

    AST_RSP_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R8

    AST_HIT_USES_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && buf_valid && !flush && buf_chan == req_chan)
            |=> rsp_ptr == $past(buf_ptr)); // R9

    AST_MISS_REFILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && buf_chan != req_chan)
            |=> buf_valid && buf_chan == $past(req_chan) && buf_ptr == rsp_ptr); // R10

    AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !req_valid) |=> !buf_valid); // R11

endmodule

// File: rtl/chptr_window.sv
// Module: top of the indirect channel pointer window. Ties the CPU
// decoder, the pointer bank and the engine lookup buffer together and
// forms the window read view. Assumes NUM_CH is between 2 and 256.
module chptr_window
    import chptr_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eng_normal,
    input  logic             cpu_wr,
    input  logic [3:0]       cpu_be,
    input  logic [31:0]      cpu_wdata,
    output logic [31:0]      cpu_rdata,
    input  logic             cfg_rbdis,
    input  logic             req_valid,
    input  logic [IDX_W-1:0] req_chan,
    output logic             rsp_valid,
    output logic [13:0]      rsp_ptr
);

    logic [SEL_W-1:0] sel_q;
    bank_wr_t         bank_wr;
    logic [PTR_W-1:0] cpu_ptr;
    logic [PTR_W-1:0] eng_ptr;

    chptr_decode #(.NUM_CH(NUM_CH)) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .eng_normal (eng_normal),
        .cpu_wr     (cpu_wr),
        .cpu_be     (cpu_be),
        .cpu_wdata  (cpu_wdata),
        .sel_q      (sel_q),
        .bank_wr    (bank_wr)
    );

    chptr_bank #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .bank_wr (bank_wr),
        .cpu_idx (sel_q),
        .cpu_ptr (cpu_ptr),
        .eng_idx (req_chan),
        .eng_ptr (eng_ptr)
    );

    chptr_rbuf #(.IDX_W(IDX_W)) u_rbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_rbdis (cfg_rbdis),
        .req_valid (req_valid),
        .req_chan  (req_chan),
        .bank_ptr  (eng_ptr),
        .rsp_valid (rsp_valid),
        .rsp_ptr   (rsp_ptr)
    );

    // Window read view, blanked outside the normal state.
    always_comb begin
        cpu_rdata = eng_normal ? pack_window(sel_q, cpu_ptr) : '0;
    end

    AST_RD_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_normal |-> cpu_rdata == 32'h0); // R5

    AST_RD_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata[15:8] == 8'h0 && cpu_rdata[31:30] == 2'b00); // R3

    AST_RD_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(sel_q) >= NUM_CH) |-> cpu_rdata[29:16] == 14'h0); // R6

endmodule

// File: tb/tb_chptr_window.sv
module tb_chptr_window;

    localparam int NUM_CH = 8;
    localparam int IDX_W  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eng_normal = 1'b1;
    logic        cpu_wr = 1'b0;
    logic [3:0]  cpu_be = 4'h0;
    logic [31:0] cpu_wdata = 32'h0;
    logic [31:0] cpu_rdata;
    logic        cfg_rbdis = 1'b0;
    logic        req_valid = 1'b0;
    logic [IDX_W-1:0] req_chan = '0;
    logic        rsp_valid;
    logic [13:0] rsp_ptr;

    always #10 clk = ~clk;

    chptr_window #(.NUM_CH(NUM_CH)) dut (
        .clk(clk), .rst_n(rst_n), .eng_normal(eng_normal),
        .cpu_wr(cpu_wr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cfg_rbdis(cfg_rbdis),
        .req_valid(req_valid), .req_chan(req_chan),
        .rsp_valid(rsp_valid), .rsp_ptr(rsp_ptr)
    );

    int checks = 0;
    int errors = 0;

    // Reference model state.
    logic [13:0] m_ptr [NUM_CH];
    logic [7:0]  m_sel;
    bit          m_norm;
    bit          m_bv;
    int          m_bc;
    logic [13:0] m_bp;
    bit          m_rb;

    // Scoreboard queues.
    logic [13:0] exp_q [$];
    string       tag_q [$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NUM_CH; i++) m_ptr[i] = '0;
        m_sel = '0; m_bv = 0; m_bc = 0; m_bp = '0; m_rb = cfg_rbdis;
        m_norm = eng_normal;
    endtask

    // All driving tasks are entered just after a falling edge.
    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic cpu_write(input logic [3:0] be, input logic [31:0] data);
        logic [7:0] nsel;
        cpu_wr = 1'b1; cpu_be = be; cpu_wdata = data;
        if (m_norm) begin
            nsel = be[0] ? data[7:0] : m_sel;
            if (be[2] && be[3] && int'(nsel) < NUM_CH) m_ptr[nsel] = data[29:16];
            m_sel = nsel;
        end
        @(negedge clk);
        cpu_wr = 1'b0; cpu_be = 4'h0;
    endtask

    task automatic check_rd(input string tag);
        logic [31:0] exp;
        #1;
        exp = '0;
        if (m_norm) begin
            exp[7:0] = m_sel;
            if (int'(m_sel) < NUM_CH) exp[29:16] = m_ptr[m_sel];
        end
        check(tag, cpu_rdata, exp);
    endtask

    task automatic set_normal(input bit v);
        eng_normal = v; m_norm = v;
        @(negedge clk);
    endtask

    task automatic set_rbdis(input bit v);
        cfg_rbdis = v;
        if (v != m_rb) m_bv = 0;
        m_rb = v;
        @(negedge clk);
    endtask

    // Driver: predict the lookup result, queue it, then pulse the request.
    task automatic issue_req(input int c, input string tag);
        logic [13:0] e;
        if (m_bv && m_bc == c) e = m_bp;
        else begin
            e = m_ptr[c]; m_bv = 1; m_bc = c; m_bp = e;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        req_valid = 1'b1; req_chan = IDX_W'(c);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: pop and compare every response.
    always @(posedge clk) begin
        #2;
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R8 unexpected response actual %h expected none", rsp_ptr);
            end else begin
                check(tag_q.pop_front(), {18'h0, rsp_ptr}, {18'h0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state of the window and first lookup
        check_rd("R1 reset view");
        issue_req(3, "R1 first lookup after reset");

        // R2: selector write on lane 0
        cpu_write(4'b0001, 32'hFFFF_FF05);
        check_rd("R2 selector");
        // R3: halfword write to the pointer field
        cpu_write(4'b1100, 32'hC000_0000 | (32'h1234 << 16) | 32'h0000_FF77);
        check_rd("R3 halfword pointer");
        // R4: word write targets the new selector
        cpu_write(4'b1111, {2'b11, 14'h2ABC, 8'hFF, 8'h02});
        check_rd("R4 word write");
        cpu_write(4'b0001, 32'h0000_0005);
        check_rd("R4 previous entry kept");
        // R7: single upper-lane writes are ignored
        cpu_write(4'b0100, {2'b00, 14'h3FFF, 16'h0});
        check_rd("R7 lane 2 only");
        cpu_write(4'b1000, {2'b00, 14'h3FFF, 16'h0});
        check_rd("R7 lane 3 only");

        // R6: selector beyond the bank
        cpu_write(4'b0001, 32'h0000_0009);
        check_rd("R6 out of range view");
        cpu_write(4'b1100, {2'b00, 14'h1111, 16'h0});
        check_rd("R6 out of range write");
        for (int i = 0; i < NUM_CH; i++) begin
            cpu_write(4'b0001, i);
            check_rd("R6 sweep entries");
        end

        // R5: no access outside the normal state
        set_normal(1'b0);
        check_rd("R5 blank read");
        cpu_write(4'b1111, {2'b00, 14'h0F0F, 8'h0, 8'h06});
        set_normal(1'b1);
        check_rd("R5 write ignored");

        // Fill the bank with distinct values.
        for (int i = 0; i < NUM_CH; i++) begin
            cpu_write(4'b1111, {2'b00, 14'(14'h0100 + 14'(i * 37)), 8'h0, 8'(i)});
        end
        check_rd("R4 fill last");

        // R8, R10: lookup miss on a new channel; R9: back-to-back hit
        issue_req(4, "R10 miss new channel");
        issue_req(4, "R9 back to back hit");
        cpu_write(4'b1111, {2'b00, 14'h2222, 8'h0, 8'h04});
        issue_req(4, "R9 stale after rewrite");
        // R11: rising change flushes
        set_rbdis(1'b1);
        issue_req(4, "R11 rising flush");
        cpu_write(4'b1111, {2'b00, 14'h3333, 8'h0, 8'h04});
        issue_req(4, "R9 stale again");
        // R11: falling change flushes
        set_rbdis(1'b0);
        issue_req(4, "R11 falling flush");
        // R10: other channel replaces buffer
        issue_req(6, "R10 switch channel");
        cpu_write(4'b1111, {2'b00, 14'h0777, 8'h0, 8'h04});
        issue_req(4, "R10 reload after switch");
        issue_req(0, "R8 channel zero");
        issue_req(7, "R8 channel seven");

        // R1: reset clears the buffer flag
        repeat (3) @(negedge clk);
        cpu_write(4'b1111, {2'b00, 14'h0ABC, 8'h0, 8'h07});
        issue_req(7, "R8 buffer seven");
        repeat (3) @(negedge clk);
        do_reset();
        check_rd("R1 reset clears bank");
        cpu_write(4'b1111, {2'b00, 14'h1357, 8'h0, 8'h07});
        issue_req(7, "R1 buffer cleared by reset");

        repeat (4) @(negedge clk);
        check("R8 all responses seen", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule